// File: doc/BRIEF.md
# Secondary Bus Arbiter with Two Priority Tiers

This block decides which master may own a shared parallel bus. There are up to nine external masters and one local bridge master, which gives ten owners in all. Each external master has an active-low request pin and an active-low grant pin. The bridge requests and receives its grant through internal signals. The block watches the frame and initiator-ready lines to tell when the bus is idle and when a granted master has started a transaction.

Priority has two levels, and the level of each owner comes from a tier-select input.
- **High tier:** owners marked high rotate round-robin.
- **Low tier:** the whole low tier takes one extra slot in the high-tier rotation. Within that slot, the low-tier owners rotate among themselves.

A grant can be withdrawn from an owner that is mid-transaction. That owner finishes the transfer it has started, because frame is already its own. A granted owner that stays idle too long loses the grant.

A strap input hands arbitration to an external arbiter. In that mode the pair of pins for master 0 changes role:
- request pin 0 carries the external grant to the bridge;
- grant pin 0 carries the bridge's request out to the external arbiter.

Top module: `sec_bus_arbiter`

## Requirements
- R1: While reset is low, every grant pin is high and the bridge grant is low.
- R2: With the internal arbiter active, at most one owner holds a grant in any cycle.
- R3: After a grant is withdrawn, at least one full cycle with no grant passes before any owner is granted again.
- R4: Owners are numbered as follows: index i (0 to 8) is the master on req_n[i]/gnt_n[i], and index 9 is the bridge. When no grant is held and any request is active, a grant is issued at the next rising edge. The winner is picked from the rotation of high-tier owners (tier_hi bit set) plus one slot for the low tier, placed after index 9. The search starts just after the slot granted last, and after reset the first slot searched is index 0.
- R5: When the low-tier slot wins, the low-tier owner (tier_hi bit clear) is picked round-robin. The search starts just after the low-tier owner granted last, and after reset it starts at index 0.
- R6: A granted owner that does not drive frame low loses its grant after 16 bus-idle cycles (frame_n and irdy_n both high). It holds the grant for exactly 16 observed cycles on an idle bus. Frame sampled low at the 16th edge keeps the grant.
- R7: If the owner's request is inactive at a rising edge, its grant is removed at that edge.
- R8: A rising edge that samples frame low while a grant is held marks the owner as started. From the following edge on, the grant is withdrawn at the first edge at which any other owner requests. Before frame is seen, other requests do not take the grant away.
- R9: With ext_arb_en high, the pins change role combinationally:
  - gnt_n[0] equals the inverse of br_req;
  - br_gnt equals the inverse of req_n[0];
  - gnt_n[8:1] stay high;
  - the internal grant state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| ext_arb_en | input | 1 | High selects the external arbiter; pair 0 changes role |
| req_n | input | N_EXT | Active-low requests of external masters; bit 0 is the external grant in external mode |
| gnt_n | output | N_EXT | Active-low grants to external masters; bit 0 is the bridge request in external mode |
| br_req | input | 1 | Bridge master request, active high |
| br_gnt | output | 1 | Grant to the bridge master, active high |
| frame_n | input | 1 | Bus frame, active low |
| irdy_n | input | 1 | Bus initiator ready, active low |
| tier_hi | input | N_EXT+1 | Per-owner tier select, 1 = high tier; bit N_EXT is the bridge |

## Verification
Two situations fall in the same cycle and matter most.

- **Timeout edge versus frame.** The 16th idle cycle of a granted owner can coincide with that owner driving frame low. The bench provokes this by asserting frame exactly on the 16th observed grant cycle, and expects the grant to survive.
- **Withdrawal versus a waiting request.** A grant withdrawal can coincide with another owner's pending request. The bench releases the owner's request while another request waits, and expects an empty grant cycle before the new owner appears.

Both cases, and long random stretches of requests, frame and irdy activity, are judged every cycle against a behavioural model of the rotation and timer rules.

// File: rtl/sba_pkg.sv
package sba_pkg;
   // arbitration source selected by the strap pin
   typedef enum logic {
      ARB_INTERNAL = 1'b0,
      ARB_EXTERNAL = 1'b1
   } arb_src_e;

   function automatic arb_src_e arb_src(input logic strap);
      return strap ? ARB_EXTERNAL : ARB_INTERNAL;
   endfunction
endpackage

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
   parameter int W  = 11,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          any,
   output logic [IW-1:0] sel
);
   generate
      if (W < 2) begin : g_bad_width
         $error("sba_rr_pick needs at least two slots");
      end
   endgenerate

   // search from the slot after 'last'; descending loop lets the nearest win
   always_comb begin
      any = 1'b0;
      sel = '0;
      for (int off = W; off >= 1; off--) begin
         int idx;
         idx = (int'(last) + off) % W;
         if (req[idx]) begin
            any = 1'b1;
            sel = IW'(idx);
         end
      end
   end
endmodule

// File: rtl/sba_park_timer.sv
module sba_park_timer #(
   parameter int LIMIT = 16,
   localparam int CW   = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic expire
);
   logic [CW-1:0] cnt_q;

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("sba_park_timer LIMIT must be at least 2");
      end
   endgenerate

   assign expire = en && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (en)  cnt_q <= cnt_q + 1'b1;
   end

   // R6: once the window is used up the owner clears the timer
   a_r6_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt_q == CW'(LIMIT - 1)) |=> (cnt_q == '0));
endmodule

// File: rtl/sba_pin_mux.sv
module sba_pin_mux
   import sba_pkg::*;
#(
   parameter int N_EXT = 9,
   localparam int N_OWN = N_EXT + 1
) (
   input  arb_src_e           src,
   input  logic [N_OWN-1:0]   gnt_vec,
   input  logic               br_req,
   input  logic               req0_n,
   output logic [N_EXT-1:0]   gnt_n,
   output logic               br_gnt
);
   genvar i;
   generate
      for (i = 0; i < N_EXT; i++) begin : g_pin
         if (i == 0) begin : g_shared
            // pin 0 carries the bridge request out in external mode
            assign gnt_n[i] = (src == ARB_EXTERNAL) ? ~br_req : ~gnt_vec[i];
         end else begin : g_plain
            assign gnt_n[i] = (src == ARB_EXTERNAL) ? 1'b1 : ~gnt_vec[i];
         end
      end
   endgenerate

   assign br_gnt = (src == ARB_EXTERNAL) ? ~req0_n : gnt_vec[N_EXT];
endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter
   import sba_pkg::*;
#(
   parameter int N_EXT      = 9,
   parameter int PARK_LIMIT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_arb_en,
   input  logic [N_EXT-1:0] req_n,
   output logic [N_EXT-1:0] gnt_n,
   input  logic             br_req,
   output logic             br_gnt,
   input  logic             frame_n,
   input  logic             irdy_n,
   input  logic [N_EXT:0]   tier_hi
);
   localparam int N_OWN   = N_EXT + 1;
   localparam int N_SLOT  = N_OWN + 1;
   localparam int LO_SLOT = N_OWN;
   localparam int OW      = $clog2(N_OWN);
   localparam int SW      = $clog2(N_SLOT);

   generate
      if (N_EXT < 1 || N_EXT > 15) begin : g_bad_count
         $error("sec_bus_arbiter supports 1 to 15 external masters");
      end
   endgenerate

   arb_src_e           src;
   logic               ext;
   logic [N_OWN-1:0]   req_all, lo_req;
   logic [N_SLOT-1:0]  slot_req;
   logic               slot_any, lo_any;
   logic [SW-1:0]      slot_sel;
   logic [OW-1:0]      lo_sel, winner;
   logic               gnt_vld_q, started_q;
   logic [OW-1:0]      owner_q, lo_last_q;
   logic [SW-1:0]      slot_last_q;
   logic [N_OWN-1:0]   gnt_vec_q;
   logic               bus_idle, others_req, drop, tmr_en, tmr_clr, expire;

   assign src      = arb_src(ext_arb_en);
   assign ext      = (src == ARB_EXTERNAL);
   assign req_all  = {br_req, ~req_n};
   assign lo_req   = req_all & ~tier_hi;
   assign slot_req = {|lo_req, req_all & tier_hi};
   assign bus_idle = frame_n & irdy_n;

   sba_rr_pick #(.W(N_SLOT)) u_slot_pick (
      .req  (slot_req),
      .last (slot_last_q),
      .any  (slot_any),
      .sel  (slot_sel)
   );

   sba_rr_pick #(.W(N_OWN)) u_low_pick (
      .req  (lo_req),
      .last (lo_last_q),
      .any  (lo_any),
      .sel  (lo_sel)
   );

   assign winner = (slot_sel == SW'(LO_SLOT)) ? lo_sel : OW'(slot_sel);

   assign others_req = |(req_all & ~gnt_vec_q);
   assign drop    = gnt_vld_q & (~req_all[owner_q] | expire | (started_q & others_req));
   assign tmr_en  = ~ext & gnt_vld_q & ~started_q & bus_idle;
   assign tmr_clr = ext | ~gnt_vld_q | drop;

   sba_park_timer #(.LIMIT(PARK_LIMIT)) u_park (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (tmr_clr),
      .en     (tmr_en),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_vld_q   <= 1'b0;
         started_q   <= 1'b0;
         owner_q     <= '0;
         gnt_vec_q   <= '0;
         slot_last_q <= SW'(LO_SLOT);
         lo_last_q   <= OW'(N_OWN - 1);
      end else if (ext) begin
         gnt_vld_q <= 1'b0;
         started_q <= 1'b0;
         gnt_vec_q <= '0;
      end else if (gnt_vld_q) begin
         if (drop) begin
            gnt_vld_q <= 1'b0;
            started_q <= 1'b0;
            gnt_vec_q <= '0;
         end else if (!frame_n) begin
            started_q <= 1'b1;
         end
      end else if (slot_any) begin
         gnt_vld_q   <= 1'b1;
         started_q   <= 1'b0;
         owner_q     <= winner;
         gnt_vec_q   <= N_OWN'(1) << winner;
         slot_last_q <= slot_sel;
         if (slot_sel == SW'(LO_SLOT)) lo_last_q <= lo_sel;
      end
   end

   sba_pin_mux #(.N_EXT(N_EXT)) u_pins (
      .src     (src),
      .gnt_vec (gnt_vec_q),
      .br_req  (br_req),
      .req0_n  (req_n[0]),
      .gnt_n   (gnt_n),
      .br_gnt  (br_gnt)
   );

   // R2: never two owners at once
   a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_vec_q));
   // R3: a grant never jumps straight to another owner
   a_r3_idle_gap: assert property (@(posedge clk) disable iff (!rst_n || ext)
      (|gnt_vec_q) |=> ((gnt_vec_q == '0) || $stable(gnt_vec_q)));
   // R4: pending request with no owner is granted on the next edge
   a_r4_prompt_grant: assert property (@(posedge clk) disable iff (!rst_n || ext)
      (!gnt_vld_q && (|req_all)) |=> gnt_vld_q);
   // R5: a low-slot win must come with a low-tier requester
   a_r5_low_slot_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_any && slot_sel == SW'(LO_SLOT)) |-> lo_any);
   // R7: owner without request loses the grant
   a_r7_release: assert property (@(posedge clk) disable iff (!rst_n || ext)
      (gnt_vld_q && !req_all[owner_q]) |=> !gnt_vld_q);
   // R9: external mode leaves no internal grant
   a_r9_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ext |=> (gnt_vec_q == '0));
endmodule

// File: tb/sec_bus_arbiter_tb.sv
module sec_bus_arbiter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NE = 9;
   localparam int NO = NE + 1;
   localparam int LIMIT = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ext_arb_en = 1'b0;
   logic [NE-1:0] req_n = '1;
   logic [NE-1:0] gnt_n;
   logic          br_req = 1'b0;
   logic          br_gnt;
   logic          frame_n = 1'b1;
   logic          irdy_n = 1'b1;
   logic [NE:0]   tier_hi = '1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int  m_vld, m_own, m_st, m_cnt, m_slot_last, m_lo_last;

   always #(CLK_PERIOD/2) clk = ~clk;

   sec_bus_arbiter #(.N_EXT(NE), .PARK_LIMIT(LIMIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .ext_arb_en(ext_arb_en),
      .req_n(req_n), .gnt_n(gnt_n), .br_req(br_req), .br_gnt(br_gnt),
      .frame_n(frame_n), .irdy_n(irdy_n), .tier_hi(tier_hi)
   );

   function automatic bit rq(int k);
      return (k == NE) ? br_req : !req_n[k];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_vld = 0; m_own = 0; m_st = 0; m_cnt = 0;
         m_slot_last = NO; m_lo_last = NO - 1;
      end else if (ext_arb_en) begin
         m_vld = 0; m_st = 0; m_cnt = 0;
      end else if (m_vld != 0) begin
         bit idle, other, lose;
         idle  = frame_n && irdy_n;
         other = 0;
         for (int k = 0; k < NO; k++) if (k != m_own && rq(k)) other = 1;
         lose = !rq(m_own) || (m_st == 0 && idle && m_cnt == LIMIT - 1) || (m_st != 0 && other);
         if (lose) begin
            m_vld = 0; m_st = 0; m_cnt = 0;
         end else begin
            if (m_st == 0 && idle) m_cnt++;
            if (!frame_n) m_st = 1;
         end
      end else begin
         bit lo_any;
         int pick;
         lo_any = 0;
         pick = -1;
         for (int k = 0; k < NO; k++) if (rq(k) && !tier_hi[k]) lo_any = 1;
         for (int off = 1; off <= NO + 1 && pick < 0; off++) begin
            int s;
            s = (m_slot_last + off) % (NO + 1);
            if (s == NO) begin
               if (lo_any) begin
                  for (int o2 = 1; o2 <= NO && pick < 0; o2++) begin
                     int m;
                     m = (m_lo_last + o2) % NO;
                     if (rq(m) && !tier_hi[m]) pick = m;
                  end
                  m_lo_last = pick;
                  m_slot_last = NO;
               end
            end else if (rq(s) && tier_hi[s]) begin
               pick = s;
               m_slot_last = s;
            end
         end
         if (pick >= 0) begin
            m_vld = 1; m_own = pick; m_st = 0; m_cnt = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int owner_seen();
      int r;
      r = -1;
      if (br_gnt) r = NE;
      for (int k = 0; k < NE; k++) if (!gnt_n[k]) r = k;
      return r;
   endfunction

   // compare against model, then return at negedge so caller may drive
   task automatic step();
      logic [NE-1:0] eg;
      logic          eb;
      @(negedge clk);
      if (ext_arb_en) begin
         eg = '1; eg[0] = ~br_req; eb = ~req_n[0];
         chk(gnt_n == eg, "R9 grant pins", 32'(gnt_n), 32'(eg));
         chk(br_gnt == eb, "R9 bridge grant", 32'(br_gnt), 32'(eb));
      end else begin
         eg = '1; eb = 1'b0;
         if (m_vld != 0) begin
            if (m_own == NE) eb = 1'b1; else eg[m_own] = 1'b0;
         end
         chk(gnt_n == eg, "R4 grant pins", 32'(gnt_n), 32'(eg));
         chk(br_gnt == eb, "R4 bridge grant", 32'(br_gnt), 32'(eb));
         chk($countones({~gnt_n, br_gnt}) <= 1, "R2 single grant",
             32'($countones({~gnt_n, br_gnt})), 32'd1);
      end
   endtask

   task automatic wait_new_owner(output int who);
      int n;
      n = 0;
      while (owner_seen() >= 0 && n < 60) begin step(); n++; end
      while (owner_seen() < 0 && n < 60) begin step(); n++; end
      who = owner_seen();
   endtask

   task automatic pulse_frame();
      frame_n = 1'b0;
      step();
      frame_n = 1'b1;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int who, n;
      logic [31:0] lf;
      lf = 32'h1ACE_5EED;
      step(); step();
      chk(gnt_n == '1, "R1 grants idle in reset", 32'(gnt_n), 32'h1FF);
      chk(br_gnt == 1'b0, "R1 bridge grant idle in reset", 32'(br_gnt), 32'h0);
      rst_n = 1'b1;
      step();

      // R4/R5 rotation: high tier {0,1,bridge}, low tier {4,5}
      tier_hi = 10'b10_0000_0011;
      req_n = 9'b1_1100_1100;
      br_req = 1'b1;
      step();
      chk(owner_seen() == 0, "R4 first grant index 0", 32'(owner_seen()), 32'd0);
      pulse_frame(); wait_new_owner(who);
      chk(who == 1, "R4 next high owner", 32'(who), 32'd1);
      pulse_frame(); wait_new_owner(who);
      chk(who == NE, "R4 bridge in rotation", 32'(who), 32'(NE));
      pulse_frame(); wait_new_owner(who);
      chk(who == 4, "R5 low slot first owner", 32'(who), 32'd4);
      pulse_frame(); wait_new_owner(who);
      chk(who == 0, "R4 wrap to index 0", 32'(who), 32'd0);
      pulse_frame(); wait_new_owner(who);
      pulse_frame(); wait_new_owner(who);
      pulse_frame(); wait_new_owner(who);
      chk(who == 5, "R5 low slot rotates", 32'(who), 32'd5);

      // R7 and R3: release owner while another waits
      req_n = '1; br_req = 1'b0;
      step(); step();
      req_n[2] = 1'b0;
      wait_new_owner(who);
      chk(who == 2, "R4 lone requester", 32'(who), 32'd2);
      req_n[3] = 1'b0; req_n[2] = 1'b1;
      step();
      chk(owner_seen() == -1, "R7 grant removed, R3 gap", 32'(owner_seen()), 32'hFFFF_FFFF);
      step();
      chk(owner_seen() == 3, "R3 next owner after gap", 32'(owner_seen()), 32'd3);
      req_n[3] = 1'b1;
      step();

      // R6 timeout length on an idle bus
      req_n[2] = 1'b0;
      wait_new_owner(who);
      n = 1;
      while (owner_seen() == 2 && n < 40) begin step(); if (owner_seen() == 2) n++; end
      chk(n == LIMIT, "R6 idle grant length", 32'(n), 32'(LIMIT));
      // R6 frame on the last cycle keeps the grant
      wait_new_owner(who);
      for (int k = 1; k < LIMIT; k++) step();
      frame_n = 1'b0;
      step();
      frame_n = 1'b1;
      chk(owner_seen() == 2, "R6 frame at limit keeps grant", 32'(owner_seen()), 32'd2);
      req_n[2] = 1'b1;
      step();
      chk(owner_seen() == -1, "R7 release after start", 32'(owner_seen()), 32'hFFFF_FFFF);

      // R8 preemption only after frame
      req_n[3] = 1'b0;
      wait_new_owner(who);
      req_n[4] = 1'b0;
      step(); step(); step();
      chk(owner_seen() == 3, "R8 no preemption before frame", 32'(owner_seen()), 32'd3);
      frame_n = 1'b0;
      step();
      frame_n = 1'b1;
      chk(owner_seen() == 3, "R8 grant held on frame edge", 32'(owner_seen()), 32'd3);
      step();
      chk(owner_seen() == -1, "R8 preempted after frame", 32'(owner_seen()), 32'hFFFF_FFFF);
      req_n = '1;
      step(); step();

      // R9 external arbiter mode
      ext_arb_en = 1'b1;
      req_n = 9'b0_0000_0000;
      br_req = 1'b1;
      step();
      chk(gnt_n == 9'b1_1111_1110, "R9 request out on pin 0", 32'(gnt_n), 32'h1FE);
      chk(br_gnt == 1'b1, "R9 grant in from pin 0", 32'(br_gnt), 32'h1);
      req_n = '1; br_req = 1'b0;
      step();
      chk(gnt_n == '1 && br_gnt == 1'b0, "R9 quiet in external mode",
          32'({gnt_n, br_gnt}), 32'h3FE);
      ext_arb_en = 1'b0;
      step(); step();

      // random traffic compared every cycle
      for (int c = 0; c < 4000; c++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         if (lf[2:0] == 3'd0) begin
            int b;
            b = int'(lf[7:4]) % NO;
            if (b == NE) br_req = ~br_req; else req_n[b] = ~req_n[b];
         end
         frame_n = (lf[11:10] != 2'b00);
         irdy_n  = (lf[13:12] != 2'b00);
         if (c % 700 == 699) tier_hi = lf[25:16];
         step();
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule